// File: doc/BRIEF.md
# Quad-Lane Serial-to-Parallel Deserializer

This block collects four single-bit serial lanes that are clocked by one fast clock and turns them into one wide parallel word. Every lane feeds its own eight-stage shift register. Once every eight fast cycles, all slices are copied at the same time into a holding register. The word is interleaved by lane index: lane k supplies bits k, k+4, k+8 and so on, and the first bit received on a lane goes to the lowest of those positions.

The block also divides the fast clock by eight and drives the result from a flop on the fast clock. This keeps the delay from the input clock short. A 2-bit phase select places the rising edge of the divided clock 0, 2, 4 or 6 fast cycles after the parallel update. Downstream logic can then pick the edge that gives it the best setup margin on the word. The block does not find frame boundaries or correct skew between lanes; the first sample after reset is taken as bit zero of every lane.

Top module: `quad_lane_deser`

## Requirements
- R1: The bit that lane k (0..3) receives as its i-th sample (i = 0..7, counted from the start of the frame) appears on `par_out[k + 4*i]`.
- R2: All 32 bits of `par_out` change only on the same fast edge, at most once every eight fast cycles, and hold steady in between.
- R3: The fast edges after reset release are numbered from 1, the first being the edge that samples the first bits. The word built from the bits sampled on edges 8n-7 to 8n is visible on `par_out` right after edge 8n.
- R4: Once running, `div_clk` has a period of eight fast cycles. It is high for four cycles and low for four.
- R5: Each rising edge of `div_clk` falls 2*`phase_sel` fast edges after a parallel update (for a setting of 0, on the update edge itself). `phase_sel` is held constant while the block is out of reset.
- R6: While `rst` is high, `par_out` is all zeros and `div_clk` is low after each fast edge.
- R7: After reset release, `par_out` stays zero until all eight bits of the first frame have been shifted in. `div_clk` stays low until its first rising edge at edge 8 + 2*`phase_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_sel | input | 2 | Divided-clock phase, offset 2*value fast cycles after the update |
| lane_in | input | 4 | Serial lanes, bit k is lane k |
| par_out | output | 32 | Registered de-interleaved parallel word |
| div_clk | output | 1 | Registered fast clock divided by eight |

## Verification
A parallel word is due right after the eighth fast edge that follows the edge which sampled its first bit. The scoreboard counts edges from reset release and compares the queued word at the falling edge after edge 8n. It also compares once halfway through each frame, where the previous word must still be present. The divided clock is compared after every edge against a level computed from the edge count and the phase setting: high when (edge - 2*setting) mod 8 is below 4, counted from edge 8 + 2*setting. One reset per phase setting gives each setting its own start.

// File: rtl/deser_pkg.sv
package deser_pkg;

  localparam int PHASE_STEPS = 4;

  typedef enum logic [1:0] {
    PH_AT_LOAD = 2'd0,
    PH_QUARTER = 2'd1,
    PH_HALF    = 2'd2,
    PH_3QUART  = 2'd3
  } phase_e;

  // Offset in fast cycles between the parallel load and the divided-clock rise.
  function automatic int phase_offset(input int sel, input int ratio);
    return sel * (ratio / PHASE_STEPS);
  endfunction

endpackage

// File: rtl/deser_slice.sv
module deser_slice #(
  parameter int RATIO = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lane_bit,
  output logic [RATIO-1:0] shift_next
);

  logic [RATIO-1:0] shift_q;

  // New bits enter at the top and move down, so the oldest ends at bit 0.
  assign shift_next = {lane_bit, shift_q[RATIO-1:1]};

  always_ff @(posedge clk) begin
    if (rst) shift_q <= '0;
    else     shift_q <= shift_next;
  end

endmodule

// File: rtl/deser_timing.sv
module deser_timing #(
  parameter int RATIO = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] phase_sel,
  output logic       load,
  output logic       div_clk
);

  localparam int CW   = $clog2(RATIO);
  localparam int HALF = RATIO / 2;

  logic [CW-1:0] cnt_q, cnt_next, offset, rel;
  logic          armed_q, armed_next;
  logic          run_q, run_next;

  assign cnt_next   = cnt_q + 1'b1;
  assign load       = (cnt_q == CW'(RATIO - 1));
  assign offset     = CW'(deser_pkg::phase_offset(int'(phase_sel), RATIO));
  assign rel        = cnt_next - offset;
  assign armed_next = armed_q | load;
  assign run_next   = run_q | (armed_next && (cnt_next == offset));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      div_clk <= 1'b0;
    end else begin
      cnt_q   <= cnt_next;
      armed_q <= armed_next;
      run_q   <= run_next;
      div_clk <= run_next && (rel < CW'(HALF));
    end
  end

endmodule

// File: rtl/quad_lane_deser.sv
module quad_lane_deser #(
  parameter int LANES = 4,
  parameter int RATIO = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               phase_sel,
  input  logic [LANES-1:0]         lane_in,
  output logic [LANES*RATIO-1:0]   par_out,
  output logic                     div_clk
);

  localparam int WORD = LANES * RATIO;

  logic [RATIO-1:0] slice_next [LANES];
  logic [WORD-1:0]  word_next;
  logic             load;

  deser_timing #(.RATIO(RATIO)) u_timing (
    .clk       (clk),
    .rst       (rst),
    .phase_sel (phase_sel),
    .load      (load),
    .div_clk   (div_clk)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    deser_slice #(.RATIO(RATIO)) u_slice (
      .clk        (clk),
      .rst        (rst),
      .lane_bit   (lane_in[k]),
      .shift_next (slice_next[k])
    );
    for (genvar i = 0; i < RATIO; i++) begin : g_bit
      assign word_next[k + LANES*i] = slice_next[k][i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       par_out <= '0;
    else if (load) par_out <= word_next;
  end

endmodule

// File: rtl/quad_lane_deser_chk.sv
module quad_lane_deser_chk #(
  parameter int LANES = 4,
  parameter int RATIO = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [1:0]             phase_sel,
  input logic [LANES*RATIO-1:0] par_out,
  input logic                   div_clk
);

  localparam int CW      = $clog2(RATIO);
  localparam int QUARTER = RATIO / 4;
  localparam int HALF    = RATIO / 2;

  logic [CW-1:0] ph;
  logic [CW:0]   hi_len;
  logic [CW+1:0] gap;
  logic [CW:0]   since_rst;
  logic          div_d, seen_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= '0; hi_len <= '0; gap <= '0; since_rst <= '0;
      div_d <= 1'b0; seen_rise <= 1'b0;
    end else begin
      ph     <= ph + 1'b1;
      div_d  <= div_clk;
      hi_len <= div_clk ? hi_len + 1'b1 : '0;
      if (div_clk && !div_d) begin
        gap       <= 1;
        seen_rise <= 1'b1;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
      if (since_rst != (CW+1)'(RATIO)) since_rst <= since_rst + 1'b1;
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (ph != '0) |-> $stable(par_out));

  assert_phase_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(div_clk) |-> (ph == CW'(CW'($past(phase_sel)) * CW'(QUARTER))));

  assert_high_len_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(div_clk) |-> (hi_len == (CW+1)'(HALF)));

  assert_period_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(div_clk) && seen_rise) |-> (gap == (CW+2)'(RATIO)));

  assert_reset_R6: assert property (@(posedge clk)
    rst |=> (par_out == '0 && !div_clk));

  assert_no_early_R7: assert property (@(posedge clk) disable iff (rst)
    (since_rst < (CW+1)'(RATIO)) |-> (par_out == '0 && !div_clk));

endmodule

bind quad_lane_deser quad_lane_deser_chk #(.LANES(LANES), .RATIO(RATIO)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .phase_sel (phase_sel),
  .par_out   (par_out),
  .div_clk   (div_clk)
);

// File: tb/quad_lane_deser_test.sv
module quad_lane_deser_test;

  localparam int LANES  = 4;
  localparam int RATIO  = 8;
  localparam int WORD   = LANES * RATIO;
  localparam int FRAMES = 7;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       phase_sel = 2'd0;
  logic [LANES-1:0] lane_in = '0;
  logic [WORD-1:0]  par_out;
  logic             div_clk;

  int tests = 0;
  int fails = 0;
  logic [WORD-1:0] exp_q[$];
  logic [WORD-1:0] last_word;

  always #5 clk = ~clk;

  quad_lane_deser #(.LANES(LANES), .RATIO(RATIO)) uut (
    .clk(clk), .rst(rst), .phase_sel(phase_sel),
    .lane_in(lane_in), .par_out(par_out), .div_clk(div_clk)
  );

  task automatic check(input string req, input logic [WORD-1:0] act, input logic [WORD-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [WORD-1:0] pick(input int sess, input int f);
    case (f)
      0: return WORD'({$urandom, $urandom});
      1: return '0;
      2: return '1;
      3: return WORD'(1) << ((sess * 7 + 3) % WORD);
      4: return WORD'(32'hA5A5_0F0F) ^ WORD'(sess);
      default: return WORD'({$urandom, $urandom});
    endcase
  endfunction

  // Driver: the expected word goes into the queue, then its bits are put on the lanes.
  // Lane k, sample i carries word bit k + 4*i (R1).
  task automatic drive_frames(input int sess);
    for (int f = 0; f < FRAMES; f++) begin
      logic [WORD-1:0] w;
      w = pick(sess, f);
      exp_q.push_back(w);
      for (int i = 0; i < RATIO; i++) begin
        for (int k = 0; k < LANES; k++) lane_in[k] = w[k + LANES*i];
        @(negedge clk);
      end
    end
    lane_in = '0;
  endtask

  // Monitor: halfway through a frame the old word must remain (R2, R7); after edge 8n the new one is due (R1, R3).
  task automatic watch_words();
    last_word = '0;
    for (int f = 0; f < FRAMES; f++) begin
      repeat (RATIO/2) @(posedge clk);
      @(negedge clk);
      check(f == 0 ? "R7 no word before eight bits" : "R2 word held mid-frame", par_out, last_word);
      repeat (RATIO/2) @(posedge clk);
      @(negedge clk);
      if (exp_q.size() == 0) begin
        check("R3 scoreboard empty", '1, '0);
      end else begin
        last_word = exp_q.pop_front();
        check("R1 R3 parallel word", par_out, last_word);
      end
    end
  endtask

  // The divided clock after edge k is high when k >= 8+2s and (k-2s) mod 8 < 4 (R4, R5, R7).
  task automatic watch_div(input int sel);
    for (int k = 1; k <= FRAMES * RATIO; k++) begin
      logic e;
      @(posedge clk);
      @(negedge clk);
      e = (k >= RATIO + 2*sel) && (((k - 2*sel) % RATIO) < RATIO/2);
      check($sformatf("R4 R5 div_clk edge %0d sel %0d", k, sel), WORD'(div_clk), WORD'(e));
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      rst = 1'b1;
      lane_in = '1;
      repeat (3) @(negedge clk);
      check("R6 par_out cleared in reset", par_out, '0);
      check("R6 div_clk low in reset", WORD'(div_clk), '0);
      phase_sel = 2'(s);
      rst = 1'b0;
      fork
        drive_frames(s);
        watch_words();
        watch_div(s);
      join
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule